// File: doc/BRIEF.md
# Programmable Test Clock Synthesizer

This block makes the test clock of a boundary-scan adapter from one fixed reference clock. Inside is a phase-accumulator oscillator: a running sum that grows by a phase step on every reference cycle, with its top bit used as the test clock. The test clock is therefore always a whole number of reference cycles high and low, and its frequency can be set very finely. A frequency command has a 16-bit code and a range bit. In the fast range one unit of the code is 1 kHz. In the slow range one unit is 1 Hz, which allows clocks down to 1 Hz.

The code is turned into a phase step by multiplying it by a constant. That constant is fixed when the design is elaborated, so the product is built only from shifted copies of the code and adders, with no general multiplier. A code of zero does not give a fixed frequency. It selects adaptive clocking: the block raises a mode flag and keeps the clock low. Fast-range codes above the supported maximum are clamped to that maximum, and a flag shows this.

The shift logic around the block uses two one-cycle strobes, one for each edge of the test clock. Each strobe is high in the same reference cycle as the clock edge it marks. A new command waits for the next falling edge of the test clock before it takes effect, so no runt high pulse can occur.

Top module: `tcs_clock_synth`

## Requirements
- R1: After reset `tck`, `tck_rise`, `tck_fall`, `adaptive` and `clamped` are all 0, and with no command no rising edge appears.
- R2: A command with `cmd_hi_range`=1 and nonzero code N (up to 12500) makes `tck` run at N kHz. Over a window of W reference cycles the number of rising edges is within 1 of W·N·1000/f_ref.
- R3: A command with `cmd_hi_range`=0 and nonzero code N makes `tck` run at N Hz, with the same rising-edge count tolerance as R2. Such a command never sets `clamped`.
- R4: A code of 0, in either range, sets `adaptive` to 1 once the command takes effect. From then on `tck` stays 0 and no strobe fires. A later nonzero code clears `adaptive` and restarts the clock.
- R5: A fast-range code above 12500 runs the clock at 12.5 MHz and sets `clamped` to 1. The next command that is within range clears `clamped`.
- R6: `tck_rise` is 1 in exactly the cycles where `tck` is 1 and was 0 one cycle before. `tck_fall` is 1 in exactly the cycles where `tck` is 0 and was 1 one cycle before.
- R7: While the clock runs, a new command takes effect only at the next falling edge of `tck`, so the current high phase keeps its full length. If several commands arrive before that edge, the last one wins. While the clock is stopped, a command takes effect on the cycle after it is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (f_ref = REF_HZ) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_hi_range | input | 1 | Range: 1 = kHz units, 0 = Hz units |
| cmd_code | input | CODE_W | Frequency code; 0 selects adaptive clocking |
| tck | output | 1 | Generated test clock |
| tck_rise | output | 1 | High in the first cycle that `tck` is 1 |
| tck_fall | output | 1 | High in the first cycle that `tck` is 0 |
| adaptive | output | 1 | Adaptive mode selected; clock held low |
| clamped | output | 1 | Active fast-range code was above the maximum |

## Verification
The bench sends commands while the clock is in mid-cycle and checks that the high phase in progress still lasts its full half period. A design that loads the new step at once would cut that phase short. In that same window it sends two commands and checks that only the second one shapes the clock that follows; a design that kept the first command would run at the clamped maximum and leave `clamped` set. It moves into and out of adaptive mode and checks that the clock is held low with no strobes, then that it restarts within one half period. A design that left the old step running, or waited for a falling edge that never comes, would fail these checks. Frequency is checked in both ranges, at the top of the slow range and beyond the fast-range limit, by counting edges, so a wrong scale constant or a missing clamp shows up as a wrong edge count.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   typedef enum logic [1:0] {
      TCS_STOPPED  = 2'd0,
      TCS_RUNNING  = 2'd1,
      TCS_ADAPTIVE = 2'd2
   } tcs_mode_e;

   // Phase step per unit of code, scaled up by 2^frac, rounded to nearest.
   function automatic logic [63:0] tcs_step_const(input longint unsigned unit_hz,
                                                  input longint unsigned ref_hz,
                                                  input int             scale_bits);
      logic [63:0] num;
      num = (64'd1 << scale_bits) * unit_hz;
      return (num + (ref_hz / 2)) / ref_hz;
   endfunction

endpackage

// File: rtl/tcs_cmd_hold.sv
module tcs_cmd_hold #(
   parameter int CODE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_hi_range,
   input  logic [CODE_W-1:0] cmd_code,
   input  logic              take,
   output logic              pend_valid,
   output logic              pend_hi_range,
   output logic [CODE_W-1:0] pend_code
);

   // Latest command waits here until the oscillator accepts it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid    <= 1'b0;
         pend_hi_range <= 1'b0;
         pend_code     <= '0;
      end else if (cmd_valid) begin
         pend_valid    <= 1'b1;
         pend_hi_range <= cmd_hi_range;
         pend_code     <= cmd_code;
      end else if (take) begin
         pend_valid    <= 1'b0;
      end
   end

endmodule

// File: rtl/tcs_const_mul.sv
module tcs_const_mul #(
   parameter int          IN_W  = 16,
   parameter int          OUT_W = 49,
   parameter logic [63:0] K     = 64'd1
) (
   input  logic [IN_W-1:0]  a,
   output logic [OUT_W-1:0] p
);

   // Multiply by a constant: one shifted copy of the input per set bit of K.
   logic [OUT_W-1:0] sum;

   always_comb begin
      sum = '0;
      for (int i = 0; i < 64; i++) begin
         if (K[i]) sum = sum + (OUT_W'(a) << i);
      end
   end

   assign p = sum;

endmodule

// File: rtl/tcs_code_to_inc.sv
module tcs_code_to_inc
   import tcs_pkg::*;
#(
   parameter int REF_HZ  = 50_000_000,
   parameter int CODE_W  = 16,
   parameter int ACC_W   = 32,
   parameter int FRAC    = 16,
   parameter int MAX_KHZ = 12_500
) (
   input  logic              hi_range,
   input  logic [CODE_W-1:0] code,
   output logic [ACC_W-1:0]  inc,
   output logic              is_zero,
   output logic              clamp
);

   localparam logic [63:0] K_LO   = tcs_step_const(64'd1,    64'(REF_HZ), ACC_W + FRAC);
   localparam logic [63:0] K_HI   = tcs_step_const(64'd1000, 64'(REF_HZ), ACC_W + FRAC);
   localparam int          KW     = $clog2(K_HI + 64'd1);
   localparam int          PROD_W = CODE_W + KW;
   localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(MAX_KHZ);

   logic [CODE_W-1:0] code_eff;
   logic [PROD_W-1:0] prod [2];

   assign clamp    = hi_range && (code > CODE_MAX);
   assign is_zero  = (code == '0);
   assign code_eff = clamp ? CODE_MAX : code;

   // One constant-multiplier per range: index 0 = Hz units, 1 = kHz units.
   for (genvar r = 0; r < 2; r++) begin : g_scale
      tcs_const_mul #(
         .IN_W  (CODE_W),
         .OUT_W (PROD_W),
         .K     ((r == 1) ? K_HI : K_LO)
      ) u_mul (
         .a (code_eff),
         .p (prod[r])
      );
   end

   assign inc = ACC_W'(prod[hi_range] >> FRAC);

endmodule

// File: rtl/tcs_phase_acc.sv
module tcs_phase_acc
   import tcs_pkg::*;
#(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_valid,
   input  logic [ACC_W-1:0] ld_inc,
   input  logic             ld_zero,
   input  logic             ld_clamp,
   output logic             take,
   output logic             tck,
   output logic             tck_rise,
   output logic             tck_fall,
   output logic             adaptive,
   output logic             clamped,
   output logic [ACC_W-1:0] inc_active
);

   localparam int MSB = ACC_W - 1;

   tcs_mode_e        mode_q;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_sum;
   logic [ACC_W-1:0] acc_next;
   logic             running;
   logic             wrap;

   assign running = (mode_q == TCS_RUNNING);
   assign acc_sum = acc_q + inc_active;
   assign wrap    = running && acc_q[MSB] && !acc_sum[MSB];
   assign take    = ld_valid && (!running || wrap);

   always_comb begin
      acc_next = acc_q;
      if (take && ld_zero) acc_next = '0;
      else if (running)    acc_next = acc_sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= TCS_STOPPED;
         acc_q      <= '0;
         inc_active <= '0;
         clamped    <= 1'b0;
         tck_rise   <= 1'b0;
         tck_fall   <= 1'b0;
      end else begin
         acc_q    <= acc_next;
         tck_rise <= acc_next[MSB] && !acc_q[MSB];
         tck_fall <= !acc_next[MSB] && acc_q[MSB];
         if (take) begin
            inc_active <= ld_inc;
            clamped    <= ld_clamp;
            mode_q     <= ld_zero ? TCS_ADAPTIVE : TCS_RUNNING;
         end
      end
   end

   assign tck      = acc_q[MSB];
   assign adaptive = (mode_q == TCS_ADAPTIVE);

endmodule

// File: rtl/tcs_clock_synth.sv
module tcs_clock_synth #(
   parameter int REF_HZ  = 50_000_000,
   parameter int CODE_W  = 16,
   parameter int ACC_W   = 32,
   parameter int FRAC    = 16,
   parameter int MAX_KHZ = 12_500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_hi_range,
   input  logic [CODE_W-1:0] cmd_code,
   output logic              tck,
   output logic              tck_rise,
   output logic              tck_fall,
   output logic              adaptive,
   output logic              clamped
);

   // Elaboration-time parameter checks.
   if (ACC_W + FRAC > 52) begin : g_bad_scale
      $error("ACC_W + FRAC must not exceed 52");
   end
   if (ACC_W < 8 || CODE_W < 2) begin : g_bad_width
      $error("ACC_W must be at least 8 and CODE_W at least 2");
   end
   if (longint'(MAX_KHZ) * 2000 > longint'(REF_HZ) || MAX_KHZ < 1) begin : g_bad_max
      $error("MAX_KHZ must be positive and at most half the reference");
   end
   if (longint'(MAX_KHZ) >= (longint'(1) << CODE_W)) begin : g_bad_code
      $error("MAX_KHZ must fit in the code field");
   end

   logic              pend_valid;
   logic              pend_hi_range;
   logic [CODE_W-1:0] pend_code;
   logic              take;
   logic [ACC_W-1:0]  ld_inc;
   logic              ld_zero;
   logic              ld_clamp;
   logic [ACC_W-1:0]  inc_active;

   tcs_cmd_hold #(.CODE_W(CODE_W)) u_hold (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_hi_range  (cmd_hi_range),
      .cmd_code      (cmd_code),
      .take          (take),
      .pend_valid    (pend_valid),
      .pend_hi_range (pend_hi_range),
      .pend_code     (pend_code)
   );

   tcs_code_to_inc #(
      .REF_HZ  (REF_HZ),
      .CODE_W  (CODE_W),
      .ACC_W   (ACC_W),
      .FRAC    (FRAC),
      .MAX_KHZ (MAX_KHZ)
   ) u_conv (
      .hi_range (pend_hi_range),
      .code     (pend_code),
      .inc      (ld_inc),
      .is_zero  (ld_zero),
      .clamp    (ld_clamp)
   );

   tcs_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_valid   (pend_valid),
      .ld_inc     (ld_inc),
      .ld_zero    (ld_zero),
      .ld_clamp   (ld_clamp),
      .take       (take),
      .tck        (tck),
      .tck_rise   (tck_rise),
      .tck_fall   (tck_fall),
      .adaptive   (adaptive),
      .clamped    (clamped),
      .inc_active (inc_active)
   );

endmodule

// File: rtl/tcs_clock_synth_chk.sv
module tcs_clock_synth_chk #(
   parameter int REF_HZ  = 50_000_000,
   parameter int MAX_KHZ = 12_500,
   parameter int ACC_W   = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tck,
   input logic             tck_rise,
   input logic             tck_fall,
   input logic             adaptive,
   input logic [ACC_W-1:0] inc_active
);

   localparam int HALF_MIN = REF_HZ / (2 * MAX_KHZ * 1000);

   logic [15:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hi_cnt <= '0;
      else if (!tck)             hi_cnt <= '0;
      else if (hi_cnt != '1)     hi_cnt <= hi_cnt + 16'd1;
   end

   assert_rise_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tck_rise |-> (tck && !$past(tck)));

   assert_fall_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tck_fall |-> (!tck && $past(tck)));

   assert_rise_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tck && !$past(tck)) |-> tck_rise);

   assert_adaptive_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adaptive |-> (!tck && !tck_rise));

   assert_update_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(inc_active) |-> !tck);

   assert_high_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tck_fall |-> (hi_cnt >= 16'(HALF_MIN)));

endmodule

bind tcs_clock_synth tcs_clock_synth_chk #(
   .REF_HZ  (REF_HZ),
   .MAX_KHZ (MAX_KHZ),
   .ACC_W   (ACC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tck        (tck),
   .tck_rise   (tck_rise),
   .tck_fall   (tck_fall),
   .adaptive   (adaptive),
   .inc_active (inc_active)
);

// File: tb/tcs_clock_synth_tb.sv
`timescale 1ns/1ps
module tcs_clock_synth_tb;

   localparam longint REF = 50_000_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_hi_range = 1'b0;
   logic [15:0] cmd_code = '0;
   logic        tck, tck_rise, tck_fall, adaptive, clamped;

   int checks = 0;
   int errors = 0;
   int strobe_bad = 0;

   always #10 clk = ~clk;

   tcs_clock_synth u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_hi_range (cmd_hi_range),
      .cmd_code     (cmd_code),
      .tck          (tck),
      .tck_rise     (tck_rise),
      .tck_fall     (tck_fall),
      .adaptive     (adaptive),
      .clamped      (clamped)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send(input bit hi, input int code);
      @(negedge clk);
      cmd_valid    = 1'b1;
      cmd_hi_range = hi;
      cmd_code     = 16'(code);
      @(negedge clk);
      cmd_valid    = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Counts edges over a window and audits the strobe rule each cycle.
   task automatic measure(input int w, output int rises, output int highs);
      logic prev;
      prev  = tck;
      rises = 0;
      highs = 0;
      for (int k = 0; k < w; k++) begin
         @(negedge clk);
         if (tck_rise) rises++;
         if (tck) highs++;
         if (tck_rise !== (tck && !prev)) strobe_bad++;
         if (tck_fall !== (!tck && prev)) strobe_bad++;
         prev = tck;
      end
   endtask

   task automatic expect_freq(input string req, input int w, input longint f_hz);
      int     n, h;
      longint exp;
      measure(w, n, h);
      exp = (longint'(w) * f_hz) / REF;
      check(n >= exp - 1 && n <= exp + 1, req, "rising edge count", n, exp);
   endtask

   task automatic t_reset;
      int n, h;
      idle(5);
      rst_n = 1'b1;
      idle(2);
      check(tck == 1'b0,      "R1", "tck after reset",      tck, 0);
      check(tck_rise == 1'b0, "R1", "tck_rise after reset", tck_rise, 0);
      check(tck_fall == 1'b0, "R1", "tck_fall after reset", tck_fall, 0);
      check(adaptive == 1'b0, "R1", "adaptive after reset", adaptive, 0);
      check(clamped == 1'b0,  "R1", "clamped after reset",  clamped, 0);
      measure(300, n, h);
      check(n == 0, "R1", "edges with no command", n, 0);
   endtask

   task automatic t_high_range;
      send(1'b1, 1000);
      idle(5);
      expect_freq("R2", 5000, 1_000_000);
      check(clamped == 1'b0, "R2", "clamped in range", clamped, 0);
      send(1'b1, 5000);
      idle(60);
      expect_freq("R2", 2000, 5_000_000);
   endtask

   task automatic t_low_range;
      send(1'b0, 50000);
      idle(30);
      expect_freq("R3", 10000, 50_000);
      send(1'b0, 65535);
      idle(1100);
      expect_freq("R3", 20000, 65_535);
      check(clamped == 1'b0, "R3", "slow range top code clamped", clamped, 0);
      send(1'b1, 50);
      idle(800);
      expect_freq("R2", 20000, 50_000);
   endtask

   task automatic t_clamp;
      send(1'b1, 20000);
      idle(1100);
      check(clamped == 1'b1, "R5", "clamped over limit", clamped, 1);
      expect_freq("R5", 1000, 12_500_000);
      send(1'b0, 60000);
      idle(20);
      check(clamped == 1'b0, "R5", "clamped cleared by in-range code", clamped, 0);
      expect_freq("R3", 10000, 60_000);
   endtask

   task automatic t_adaptive;
      int n, h, first;
      send(1'b1, 1000);
      idle(900);
      send(1'b1, 0);
      idle(60);
      check(adaptive == 1'b1, "R4", "adaptive set by code zero", adaptive, 1);
      check(tck == 1'b0,      "R4", "tck held in adaptive", tck, 0);
      measure(1000, n, h);
      check(n == 0 && h == 0, "R4", "edges or high cycles in adaptive", n + h, 0);
      send(1'b1, 1000);
      first = -1;
      for (int k = 1; k <= 40; k++) begin
         @(negedge clk);
         if (tck_rise && first < 0) first = k;
      end
      check(adaptive == 1'b0, "R4", "adaptive cleared by nonzero code", adaptive, 0);
      check(first >= 20 && first <= 30, "R7", "cycles to first edge from stop", first, 26);
      expect_freq("R4", 5000, 1_000_000);
   endtask

   task automatic t_update_at_fall;
      int hi;
      send(1'b1, 100);
      idle(60);
      for (int k = 0; k < 2000 && !tck_rise; k++) @(negedge clk);
      hi = 1;
      for (int k = 1; k < 1000; k++) begin
         @(negedge clk);
         if (!tck) break;
         hi++;
         if (k == 50) begin
            cmd_valid = 1'b1; cmd_hi_range = 1'b1; cmd_code = 16'd30000;
         end else if (k == 51) begin
            cmd_code = 16'd2000;
         end else if (k == 52) begin
            cmd_valid = 1'b0;
         end
      end
      cmd_valid = 1'b0;
      check(hi >= 245 && hi <= 255, "R7", "high phase across command", hi, 250);
      idle(20);
      check(clamped == 1'b0, "R7", "last command wins (clamped)", clamped, 0);
      expect_freq("R7", 2000, 2_000_000);
   endtask

   initial begin
      t_reset();
      t_high_range();
      t_low_range();
      t_clamp();
      t_adaptive();
      t_update_at_fall();
      check(strobe_bad == 0, "R6", "strobe mismatches", strobe_bad, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule